// File: doc/BRIEF.md
# Two-Digit Multiplexed Display Dimmer Sequencer

This block sequences a 1/2-duty multiplexed display in which 19 segment lines are shared by two digit enables. It alternates between a first-digit slot and a second-digit slot of fixed length, 2048 clocks each, so a full frame is 4096 clocks. In every slot it opens a short fixed guard window in which both digits are dark before the segment lines switch to the new digit's data. The enable of the active digit then rises after a programmable off-time and stays high to the end of the slot. The off-time is what sets brightness.

A host loads a 38-bit segment image, a 10-bit dimmer value and a mode bit with a single-cycle load strobe. In digital mode the loaded dimmer value sets the off-time. In analog mode the loaded dimmer value is ignored: a 6-bit code, typically from an external converter, indexes a parameter table that yields an equivalent 10-bit dimmer value. An active-low blank input darkens both digits at once and leaves all held state intact.

Top module: `vfd_half_duty_seq`

## Requirements
- R1: After reset both digit enables are low and all segment outputs are 0. This lasts until the first slot that starts after a load strobe.
- R2: The slot counter runs 2048 clocks per slot, starting with the first digit after reset and then alternating. The two digit enables are never high together.
- R3: Segment outputs change only at slot position 2, which is the fixed guard of 2 clocks after the slot begins. Both digits are low during positions 0 and 1.
- R4: The off-time t2 = ceil(2044·(1023−D)/1023), where D is the effective dimmer value. The digit is high from position 2+t2 to position 2047. So D=0x3FF gives t2=0, D=0x3FE gives t2=2, and D=0 gives t2=2044.
- R5: In a first-digit slot, seg_o[i] shows image bit i (bits 18..0). In a second-digit slot, seg_o[i] shows image bit i+19 (bits 37..19). A 1 means the segment is lit.
- R6: While blank_ni is low, both digit enables are low in the same cycle. Segment outputs and held settings are kept, and a load taken during blanking is honoured.
- R7: With the mode bit set to 1 (analog), D is the table entry for code_i, and the loaded dimmer value has no effect. The default table entry for code c is floor(c·1023/63).
- R8: A load strobe captures the image, the dimmer value and the mode bit on that clock edge. New dimmer and mode values take effect at the next slot start. New segment data appears at the next guard end.
- R9: code_i is sampled only at the slot start. A change within a slot has no effect until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for image, dimmer value and mode |
| seg_data_i | input | 38 | Segment image; bits 18..0 first digit, 37..19 second digit |
| dim_i | input | 10 | Digital dimmer value |
| analog_i | input | 1 | Mode bit: 1 selects the code-table dimmer |
| code_i | input | 6 | Analog dimmer code |
| blank_ni | input | 1 | Display blank, active low |
| seg_o | output | 19 | Segment outputs |
| dig1_o | output | 1 | First digit enable |
| dig2_o | output | 1 | Second digit enable |

## Verification
The assertions assume that every input is synchronous to clk_i and holds a known value once reset is released. They also assume a guard of at least one clock and a span that leaves the off-time inside a slot. The stimulus changes inputs only shortly after falling edges and gives load only as a single-cycle strobe. It changes dimmer, mode, code and blank at arbitrary slot positions, including mid-slot, so that the slot-boundary sampling is exercised without breaking those assumptions.

// File: rtl/vfd_seq_pkg.sv
package vfd_seq_pkg;
  localparam int DIM_W   = 10;
  localparam int CODE_W  = 6;
  localparam int CURVE_N = 2 ** CODE_W;

  typedef logic [DIM_W-1:0] dim_t;
  typedef dim_t [CURVE_N-1:0] curve_t;

  // linear default: code 0 -> 0, full code -> full dimmer
  function automatic curve_t default_curve();
    curve_t r;
    for (int c = 0; c < CURVE_N; c++)
      r[c] = dim_t'((c * (2 ** DIM_W - 1)) / (CURVE_N - 1));
    return r;
  endfunction
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
  parameter int SLOT_CLKS  = 2048,
  parameter int GUARD_CLKS = 2,
  parameter int CNT_W      = $clog2(SLOT_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             slot_o,
  output logic             slot_end_o,
  output logic             guard_end_o
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_CLKS - 1);
  localparam logic [CNT_W-1:0] GEDGE = CNT_W'(GUARD_CLKS - 1);

  assign slot_end_o  = (cnt_o == LAST);
  assign guard_end_o = (cnt_o == GEDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      slot_o <= 1'b0;
    end else if (slot_end_o) begin
      cnt_o  <= '0;
      slot_o <= ~slot_o;
    end else begin
      cnt_o  <= cnt_o + 1'b1;
    end
  end

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |=> (cnt_o == '0) && (slot_o != $past(slot_o))); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_o |=> $stable(slot_o)); // R2
endmodule

// File: rtl/vfd_dim_select.sv
module vfd_dim_select
  import vfd_seq_pkg::*;
#(
  parameter curve_t CURVE = default_curve()
) (
  input  logic              analog_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIM_W-1:0]  dm_i,
  output logic [DIM_W-1:0]  dm_o
);
  assign dm_o = analog_i ? CURVE[code_i] : dm_i;
endmodule

// File: rtl/vfd_offtime_calc.sv
module vfd_offtime_calc #(
  parameter int SPAN  = 2044,
  parameter int DIM_W = 10,
  parameter int T_W   = 11
) (
  input  logic [DIM_W-1:0] dm_i,
  output logic [T_W-1:0]   t2_o
);
  localparam longint unsigned DMAX    = (64'd1 << DIM_W) - 64'd1;
  localparam longint unsigned SPAN_U  = 64'(SPAN);
  localparam longint unsigned NUM_MAX = SPAN_U * DMAX + DMAX - 64'd1;
  localparam int              NUM_W   = $clog2(NUM_MAX + 64'd1);
  localparam int              SH      = NUM_W + DIM_W;
  // ceil(2^SH / DMAX): exact floor division for every numerator below 2^NUM_W
  localparam longint unsigned RECIP   = ((64'd1 << SH) + DMAX - 64'd1) / DMAX;
  localparam int              PROD_W  = 2 * NUM_W + 2;

  logic [NUM_W-1:0]  num;
  logic [PROD_W-1:0] prod;

  // ceil(SPAN*(DMAX-dm)/DMAX) == floor((SPAN*(DMAX-dm) + DMAX-1)/DMAX)
  assign num  = NUM_W'(SPAN_U * (DMAX - 64'(dm_i)) + DMAX - 64'd1);
  assign prod = PROD_W'(num) * PROD_W'(RECIP);
  assign t2_o = T_W'(prod >> SH);
endmodule

// File: rtl/vfd_half_duty_seq.sv
module vfd_half_duty_seq
  import vfd_seq_pkg::*;
#(
  parameter int     SLOT_CLKS  = 2048,
  parameter int     GUARD_CLKS = 2,
  parameter int     NSEG       = 19,
  parameter curve_t CURVE      = default_curve()
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*NSEG-1:0]   seg_data_i,
  input  logic [DIM_W-1:0]    dim_i,
  input  logic                analog_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                blank_ni,
  output logic [NSEG-1:0]     seg_o,
  output logic                dig1_o,
  output logic                dig2_o
);
  localparam int CNT_W = $clog2(SLOT_CLKS);
  localparam int SPAN  = SLOT_CLKS - 2 * GUARD_CLKS;
  localparam logic [DIM_W-1:0] DMAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic              slot_q, slot_end, guard_end;
  logic [2*NSEG-1:0] img_q;
  logic [DIM_W-1:0]  dm_q, eff_dm;
  logic              mode_q, armed_q, live_q;
  logic [CNT_W-1:0]  t2, t2_q;
  logic              on_win;

  vfd_slot_timer #(
    .SLOT_CLKS (SLOT_CLKS),
    .GUARD_CLKS(GUARD_CLKS),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_o      (cnt_q),
    .slot_o     (slot_q),
    .slot_end_o (slot_end),
    .guard_end_o(guard_end)
  );

  vfd_dim_select #(.CURVE(CURVE)) u_dsel (
    .analog_i(mode_q),
    .code_i  (code_i),
    .dm_i    (dm_q),
    .dm_o    (eff_dm)
  );

  vfd_offtime_calc #(.SPAN(SPAN), .DIM_W(DIM_W), .T_W(CNT_W)) u_calc (
    .dm_i(eff_dm),
    .t2_o(t2)
  );

  // host-side hold registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_q   <= '0;
      dm_q    <= '0;
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      img_q   <= seg_data_i;
      dm_q    <= dim_i;
      mode_q  <= analog_i;
      armed_q <= 1'b1;
    end
  end

  // per-slot settings, frozen at the slot boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t2_q   <= '0;
      live_q <= 1'b0;
    end else if (slot_end) begin
      t2_q   <= t2;
      live_q <= armed_q;
    end
  end

  // segment switch at guard end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o <= '0;
    end else if (guard_end) begin
      if (!live_q)     seg_o <= '0;
      else if (slot_q) seg_o <= img_q[2*NSEG-1:NSEG];
      else             seg_o <= img_q[NSEG-1:0];
    end
  end

  assign on_win = ({1'b0, cnt_q} >= ((CNT_W+1)'(GUARD_CLKS) + {1'b0, t2_q}));
  assign dig1_o = blank_ni & live_q & ~slot_q & on_win;
  assign dig2_o = blank_ni & live_q &  slot_q & on_win;

  AST_DIGIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dig1_o && dig2_o)); // R2
  AST_GUARD_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < CNT_W'(GUARD_CLKS)) |-> (!dig1_o && !dig2_o)); // R3
  AST_SEG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_W'(GUARD_CLKS)) |-> $stable(seg_o)); // R3
  AST_UNARMED_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (seg_o == '0 && !dig1_o && !dig2_o)); // R1
  AST_T2_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_q <= CNT_W'(SPAN)); // R4
  AST_FULL_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_dm == DMAX) |-> (t2 == '0)); // R4
  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (!dig1_o && !dig2_o)); // R6
endmodule

// File: tb/vfd_half_duty_seq_tb_top.sv
module vfd_half_duty_seq_tb_top;
  localparam int SLOT = 2048;
  localparam int G    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [37:0] seg_data = '0;
  logic [9:0]  dim = '0;
  logic        analog = 1'b0;
  logic [5:0]  code = '0;
  logic        blank_n = 1'b1;
  logic [18:0] seg;
  logic        dig1, dig2;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vfd_half_duty_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seg_data_i(seg_data),
    .dim_i(dim), .analog_i(analog), .code_i(code), .blank_ni(blank_n),
    .seg_o(seg), .dig1_o(dig1), .dig2_o(dig2)
  );

  function automatic int curve_f(int c);
    return (c * 1023) / 63;
  endfunction
  function automatic int t2_f(int d);
    return (2044 * (1023 - d) + 1022) / 1023;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int          m_cnt, m_t2;
  bit          m_slot, m_live, m_armed, m_mode;
  logic [37:0] m_img;
  int          m_dm;
  logic [18:0] m_seg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_slot = 0; m_live = 0; m_armed = 0; m_mode = 0;
      m_t2 = 0; m_img = '0; m_dm = 0; m_seg = '0;
    end else begin
      if (m_cnt == G - 1) m_seg = !m_live ? '0 : (m_slot ? m_img[37:19] : m_img[18:0]);
      if (m_cnt == SLOT - 1) begin
        m_t2   = t2_f(m_mode ? curve_f(int'(code)) : m_dm);
        m_live = m_armed;
        m_slot = !m_slot;
        m_cnt  = 0;
      end else m_cnt++;
      if (load) begin
        m_img = seg_data; m_dm = int'(dim); m_mode = analog; m_armed = 1;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit on, e1, e2;
      on = blank_n && m_live && (m_cnt >= G + m_t2);
      e1 = on && !m_slot;
      e2 = on && m_slot;
      chk(seg === m_seg, "R5", "seg_o", seg, m_seg);
      chk(dig1 === e1, blank_n ? "R4" : "R6", "dig1_o", dig1, e1);
      chk(dig2 === e2, blank_n ? "R4" : "R6", "dig2_o", dig2, e2);
      chk(!(dig1 && dig2), "R2", "digit overlap", {dig1, dig2}, 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [37:0] img, logic [9:0] d, logic a);
    @(negedge clk);
    seg_data = img; dim = d; analog = a; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_pos(int pos, bit slot);
    do @(negedge clk); while (!(m_cnt == pos && m_slot == slot));
  endtask

  // rise position of the digit in the next slot of the given digit
  task automatic measure(string req, bit which, int exp_t2);
    int rise;
    wait_pos(0, which);
    rise = -1;
    for (int i = 0; i < SLOT; i++) begin
      #2;
      if ((which ? dig2 : dig1) && rise < 0) rise = m_cnt;
      @(negedge clk);
    end
    chk(rise == G + exp_t2, req, "rise position", rise, G + exp_t2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2); #2;
    chk(seg == '0 && !dig1 && !dig2, "R1", "reset outputs", {seg, dig1, dig2}, 0);
    cyc(100); #2;
    chk(seg == '0 && !dig1 && !dig2, "R1", "unloaded dark", {seg, dig1, dig2}, 0);

    // R8: load mid-slot, first slot stays dark
    do_load({19'h2A5C3, 19'h51E7F}, 10'h3FE, 1'b0);
    wait_pos(2000, 0); #2;
    chk(seg == '0 && !dig1, "R1", "dark before boundary", {seg, dig1}, 0);

    measure("R4", 1'b1, 2);                   // 0x3FE
    wait_pos(1, 0); #2;
    chk(seg == 19'h2A5C3, "R3", "seg before guard end", seg, 19'h2A5C3);
    wait_pos(2, 0); #2;
    chk(seg == 19'h51E7F, "R5", "first digit image", seg, 19'h51E7F);
    wait_pos(2, 1); #2;
    chk(seg == 19'h2A5C3, "R5", "second digit image", seg, 19'h2A5C3);

    do_load({19'h7FFFF, 19'h00001}, 10'h3FF, 1'b0);
    measure("R4", 1'b0, 0);
    do_load({19'h00010, 19'h40000}, 10'h000, 1'b0);
    measure("R4", 1'b1, 2044);
    do_load({19'h12345, 19'h6789A}, 10'h0FF, 1'b0);
    measure("R4", 1'b0, 1535);

    // R6 blank
    wait_pos(1900, 1);
    blank_n = 1'b0; #2;
    chk(!dig1 && !dig2, "R6", "blanked digits", {dig1, dig2}, 0);
    chk(seg == 19'h12345, "R6", "segments kept", seg, 19'h12345);
    do_load({19'h0F0F0, 19'h70707}, 10'h3FE, 1'b0);
    cyc(3000);
    blank_n = 1'b1;
    wait_pos(2, 0); #2;
    chk(seg == 19'h70707, "R6", "load during blank", seg, 19'h70707);
    measure("R6", 1'b1, 2);

    // R7 analog mode, dimmer value ignored
    do_load({19'h0F0F0, 19'h70707}, 10'h3FF, 1'b1);
    code = 6'd40;
    measure("R7", 1'b0, t2_f(curve_f(40)));
    do_load({19'h0F0F0, 19'h70707}, 10'h000, 1'b1);
    measure("R7", 1'b1, t2_f(curve_f(40)));
    code = 6'd63;
    measure("R7", 1'b0, 0);

    // R9 code change mid-slot
    code = 6'd0;
    wait_pos(100, 1);
    code = 6'd10;
    measure("R9", 1'b0, t2_f(curve_f(10)));
    wait_pos(100, 1);
    code = 6'd0;
    cyc(1);
    wait_pos(2047, 1); #2;
    chk(dig2 == 1'b1, "R9", "late code change held", dig2, 1);

    // back to digital
    do_load({19'h00000, 19'h7FFFF}, 10'h200, 1'b0);
    measure("R8", 1'b0, t2_f(10'h200));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule